// File: doc/BRIEF.md
# Reversible Branch Condition Code

This block keeps the condition code that decides conditional branches. The code is held as four answer bits, one for each of the four branch tests: positive non-zero, non-zero, negative and no overflow. A branch reads its bit and takes the jump when that bit is 1. The code is loaded from a result word and an overflow indication whenever the datapath strobes an update.

A reverse command rewrites the code into a second, reversed encoding. The next conditional branch then tests the complementary condition: negative-or-zero, zero, positive-or-zero, or overflow. The reversal stays in force across any number of cycles that carry no branch, so an index-modifier instruction can sit between the reverse command and the branch. While it is in force, the code is frozen against updates. The first branch that follows uses the reversed code and then returns the code to its normal form.

A save register can capture the whole state (code plus reversed flag) and give it back later. This serves entry to and exit from interrupt tasks.

Top module: `cc_rev_branch_unit`

## Requirements
- R1: After synchronous reset the code is the zero code 4'b0001, the state is normal (not reversed) and `br_taken` is 0.
- R2: An update (`upd_en`, normal state, no higher-priority command in the same cycle) stores the classification of `res_val`. The bit order is [3]=positive-non-zero, [2]=non-zero, [1]=negative, [0]=no-overflow. Overflow is `res_ovf`, or a mismatch between the two most significant bits of `res_val`. Overflow gives 4'b0000 and takes precedence over sign and zero. Otherwise zero gives 4'b0001, a set top bit gives 4'b0111 and any other value gives 4'b1101.
- R3: `br_sel` picks the tested bit: 0 picks bit 3, 1 picks bit 2, 2 picks bit 1 and 3 picks bit 0. `br_taken` is registered. It goes to the selected bit of the code held in the cycle where `br_en` is high, and is 0 in the cycle after any cycle without `br_en`.
- R4: A reverse command in normal state translates the code as follows: 0001→1110, 1101→0010, 0111→1000 and 0000→0001. The state then becomes reversed.
- R5: While reversed, update strobes are ignored and the code does not change.
- R6: A branch in reversed state, taken or not, uses the reversed code and then restores the matching normal code: 1110→0001, 0010→1101, 1000→0111 and 0001→0000.
- R7: The reversal persists across cycles without a branch. A second reverse command while already reversed has no effect.
- R8: `save_en` copies the code and the reversed flag into the save register. `restore_en` loads both back, so a restored reversed code is again locked against updates.
- R9: The priority within one cycle is restore, then branch, then reverse, then update. A save in the same cycle captures the state held before that cycle's change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_val | input | DATA_W | Result word to classify |
| res_ovf | input | 1 | External overflow indication for `res_val` |
| upd_en | input | 1 | Load the code from the result |
| rev_cmd | input | 1 | Reverse the sense of the next branch |
| br_en | input | 1 | Conditional branch evaluated this cycle |
| br_sel | input | 2 | Which branch test is evaluated |
| save_en | input | 1 | Copy state into the save register |
| restore_en | input | 1 | Load state from the save register |
| br_taken | output | 1 | Registered branch decision |

## Verification
The bench builds the block with `DATA_W` = 6. This makes all 64 result words, each with and without the external overflow flag, a small enough set to sweep in full. That sweep reaches every mismatch of the top two bits and every sign/zero case. The full code is read back without disturbing it: the bench saves the state, then issues four branches, each combined with a restore. Each of the four classes is then driven through reversal, blocked update, repeated reversal and the consuming branch. Same-cycle collisions of the commands are also exercised.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CC_W  = 4;
  localparam int SEL_W = $clog2(CC_W);

  typedef logic [CC_W-1:0] cc_code_t;

  // normal encodings, bits [3:0] = pnz, nz, neg, nov
  localparam cc_code_t CC_ZERO = 4'b0001;
  localparam cc_code_t CC_POS  = 4'b1101;
  localparam cc_code_t CC_NEG  = 4'b0111;
  localparam cc_code_t CC_OVF  = 4'b0000;
  // encodings while the next branch is reversed
  localparam cc_code_t CCR_ZERO = 4'b1110;
  localparam cc_code_t CCR_POS  = 4'b0010;
  localparam cc_code_t CCR_NEG  = 4'b1000;
  localparam cc_code_t CCR_OVF  = 4'b0001;

  typedef enum logic [SEL_W-1:0] {
    SEL_PNZ = 2'd0,
    SEL_NZ  = 2'd1,
    SEL_NEG = 2'd2,
    SEL_NOV = 2'd3
  } br_sel_e;

  typedef struct packed {
    cc_code_t code;
    logic     rev;
  } cc_state_t;
endpackage

// File: rtl/cc_classify.sv
module cc_classify
  import cc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] val,
  input  logic              ovf_in,
  output cc_code_t          code
);
  localparam int TOP = DATA_W - 1;
  localparam int NXT = DATA_W - 2;

  logic ovf;
  logic is_zero;

  assign ovf     = ovf_in | (val[TOP] ^ val[NXT]);
  assign is_zero = ~|val;

  always_comb begin
    if (ovf)            code = CC_OVF;
    else if (is_zero)   code = CC_ZERO;
    else if (val[TOP])  code = CC_NEG;
    else                code = CC_POS;
  end
endmodule

// File: rtl/cc_flip.sv
module cc_flip
  import cc_pkg::*;
(
  input  cc_code_t code_in,
  input  logic     to_normal,
  output cc_code_t code_out
);
  always_comb begin
    code_out = code_in;
    if (!to_normal) begin
      case (code_in)
        CC_ZERO: code_out = CCR_ZERO;
        CC_POS:  code_out = CCR_POS;
        CC_NEG:  code_out = CCR_NEG;
        CC_OVF:  code_out = CCR_OVF;
        default: code_out = code_in;
      endcase
    end else begin
      case (code_in)
        CCR_ZERO: code_out = CC_ZERO;
        CCR_POS:  code_out = CC_POS;
        CCR_NEG:  code_out = CC_NEG;
        CCR_OVF:  code_out = CC_OVF;
        default:  code_out = code_in;
      endcase
    end
  end
endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval
  import cc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             br_en,
  input  logic [SEL_W-1:0] br_sel,
  input  cc_code_t         code,
  output logic             br_taken
);
  // reorder so that select value i addresses answer bit CC_W-1-i
  logic [CC_W-1:0] by_sel;

  genvar gi;
  generate
    for (gi = 0; gi < CC_W; gi++) begin : g_order
      assign by_sel[gi] = code[CC_W-1-gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) br_taken <= 1'b0;
    else     br_taken <= br_en & by_sel[br_sel];
  end

  assert_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
    !br_en |=> !br_taken);
endmodule

// File: rtl/cc_rev_branch_unit.sv
module cc_rev_branch_unit
  import cc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] res_val,
  input  logic              res_ovf,
  input  logic              upd_en,
  input  logic              rev_cmd,
  input  logic              br_en,
  input  logic [1:0]        br_sel,
  input  logic              save_en,
  input  logic              restore_en,
  output logic              br_taken
);
  cc_code_t  code_q;
  logic      rev_q;
  cc_state_t save_q;
  cc_code_t  cls_code;
  cc_code_t  flip_code;

  cc_classify #(.DATA_W(DATA_W)) u_cls (
    .val    (res_val),
    .ovf_in (res_ovf),
    .code   (cls_code)
  );

  cc_flip u_flip (
    .code_in   (code_q),
    .to_normal (rev_q),
    .code_out  (flip_code)
  );

  cc_branch_eval u_br (
    .clk      (clk),
    .rst      (rst),
    .br_en    (br_en),
    .br_sel   (br_sel),
    .code     (code_q),
    .br_taken (br_taken)
  );

  // save register: captures state held before this cycle's change
  always_ff @(posedge clk) begin
    if (rst)          save_q <= '{code: CC_ZERO, rev: 1'b0};
    else if (save_en) save_q <= '{code: code_q, rev: rev_q};
  end

  // code register: restore > branch > reverse > update
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= CC_ZERO;
      rev_q  <= 1'b0;
    end else if (restore_en) begin
      code_q <= save_q.code;
      rev_q  <= save_q.rev;
    end else if (br_en) begin
      if (rev_q) begin
        code_q <= flip_code;
        rev_q  <= 1'b0;
      end
    end else if (rev_cmd) begin
      if (!rev_q) begin
        code_q <= flip_code;
        rev_q  <= 1'b1;
      end
    end else if (upd_en && !rev_q) begin
      code_q <= cls_code;
    end
  end

  assert_legal_normal_R2: assert property (@(posedge clk) disable iff (rst)
    !rev_q |-> (code_q == CC_ZERO || code_q == CC_POS ||
                code_q == CC_NEG  || code_q == CC_OVF));

  assert_legal_reversed_R4: assert property (@(posedge clk) disable iff (rst)
    rev_q |-> (code_q == CCR_ZERO || code_q == CCR_POS ||
               code_q == CCR_NEG  || code_q == CCR_OVF));

  assert_update_locked_R5: assert property (@(posedge clk) disable iff (rst)
    (rev_q && upd_en && !restore_en && !br_en) |=> $stable(code_q));

  assert_branch_consumes_R6: assert property (@(posedge clk) disable iff (rst)
    (br_en && !restore_en) |=> !rev_q);

  assert_reversal_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (rev_q && !br_en && !restore_en) |=> (rev_q && $stable(code_q)));

  assert_restore_loads_R8: assert property (@(posedge clk) disable iff (rst)
    restore_en |=> (code_q == $past(save_q.code) && rev_q == $past(save_q.rev)));
endmodule

// File: tb/cc_rev_branch_unit_tb.sv
`timescale 1ns/1ps
module cc_rev_branch_unit_tb_top;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] res_val;
  logic         res_ovf, upd_en, rev_cmd, br_en, save_en, restore_en;
  logic [1:0]   br_sel;
  logic         br_taken;

  int n_chk = 0;
  int n_bad = 0;

  // bench model of the state
  logic [3:0] m_code, m_scode;
  logic       m_rev, m_srev;

  always #2.5 clk = ~clk;

  cc_rev_branch_unit #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .res_val(res_val), .res_ovf(res_ovf),
    .upd_en(upd_en), .rev_cmd(rev_cmd), .br_en(br_en), .br_sel(br_sel),
    .save_en(save_en), .restore_en(restore_en), .br_taken(br_taken)
  );

  function automatic logic [3:0] exp_class(input int u, input logic o);
    int half, quarter;
    logic top, nxt;
    half = 1 << (W - 1);
    quarter = 1 << (W - 2);
    top = (u >= half);
    nxt = ((u % half) >= quarter);
    if (o || (top != nxt)) return 4'b0000;
    if (u == 0)            return 4'b0001;
    if (top)               return 4'b0111;
    return 4'b1101;
  endfunction

  function automatic logic [3:0] exp_rev(input logic [3:0] c);
    case (c)
      4'b0001: return 4'b1110;
      4'b1101: return 4'b0010;
      4'b0111: return 4'b1000;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [3:0] exp_norm(input logic [3:0] c);
    case (c)
      4'b1110: return 4'b0001;
      4'b0010: return 4'b1101;
      4'b1000: return 4'b0111;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    res_val = '0; res_ovf = 0; upd_en = 0; rev_cmd = 0; br_en = 0;
    br_sel = 0; save_en = 0; restore_en = 0;
  endtask

  // one cycle of stimulus; starts and ends at a falling edge
  task automatic apply(input logic u, input int v, input logic o, input logic rv,
                       input logic b, input int s, input logic sv, input logic rs,
                       output logic got, output logic exp_t);
    logic [3:0] sc; logic sr;
    res_val = W'(v); res_ovf = o; upd_en = u; rev_cmd = rv; br_en = b;
    br_sel = 2'(s); save_en = sv; restore_en = rs;
    exp_t = b ? m_code[3 - s] : 1'b0;
    sc = m_scode; sr = m_srev;
    if (sv) begin m_scode = m_code; m_srev = m_rev; end
    if (rs) begin m_code = sc; m_rev = sr; end
    else if (b) begin
      if (m_rev) begin m_code = exp_norm(m_code); m_rev = 0; end
    end else if (rv) begin
      if (!m_rev) begin m_code = exp_rev(m_code); m_rev = 1; end
    end else if (u && !m_rev) m_code = exp_class(v, o);
    @(negedge clk);
    idle_inputs();
    got = br_taken;
  endtask

  // read the full code without changing it
  task automatic probe(input string req);
    logic g, e;
    logic [3:0] seen, want;
    want = m_code;
    apply(0, 0, 0, 0, 0, 0, 1, 0, g, e);
    for (int s = 0; s < 4; s++) begin
      apply(0, 0, 0, 0, 1, s, 0, 1, g, e);
      seen[3 - s] = g;
    end
    chk(req, seen, want);
  endtask

  task automatic upd(input int v, input logic o);
    logic g, e;
    apply(1, v, o, 0, 0, 0, 0, 0, g, e);
  endtask

  task automatic rev();
    logic g, e;
    apply(0, 0, 0, 1, 0, 0, 0, 0, g, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic g, e;
    int vals[4];
    idle_inputs();
    rst = 1;
    m_code = 4'b0001; m_rev = 0; m_scode = 4'b0001; m_srev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 br_taken after reset", {3'b0, br_taken}, 4'b0);
    probe("R1 reset code");

    // R2 exhaustive classification sweep
    for (int v = 0; v < (1 << W); v++) begin
      for (int o = 0; o < 2; o++) begin
        upd(v, o[0]);
        probe("R2 classify");
      end
    end

    // R3 each selector on a known code, and low without branch
    upd(5, 0);   // positive: 1101
    for (int s = 0; s < 4; s++) begin
      apply(0, 0, 0, 0, 1, s, 0, 0, g, e);
      chk("R3 branch select", {3'b0, g}, {3'b0, e});
    end
    apply(0, 0, 0, 0, 0, 0, 0, 0, g, e);
    chk("R3 no branch low", {3'b0, g}, 4'b0);

    // R4-R7 per class: zero, positive, negative, overflow
    vals[0] = 0; vals[1] = 3; vals[2] = 48; vals[3] = 16;
    for (int k = 0; k < 4; k++) begin
      upd(vals[k], 0);
      rev();
      probe("R4 reversed code");
      upd((k == 0) ? 5 : 0, 0);
      probe("R5 update ignored while reversed");
      rev();
      repeat (3) apply(0, 0, 0, 0, 0, 0, 0, 0, g, e);
      probe("R7 reversal persists, second reverse no effect");
      apply(0, 0, 0, 0, 1, k, 0, 0, g, e);
      chk("R6 branch uses reversed code", {3'b0, g}, {3'b0, e});
      probe("R6 branch restores normal code");
      upd(0, 1);
      probe("R6 updates accepted after branch");
    end

    // R8 save reversed positive, restore after other activity
    upd(7, 0);
    rev();
    apply(0, 0, 0, 0, 0, 0, 1, 0, g, e);
    apply(0, 0, 0, 0, 1, 0, 0, 0, g, e);
    upd(40, 0);
    apply(0, 0, 0, 0, 0, 0, 0, 1, g, e);
    probe("R8 restored reversed code");
    upd(0, 0);
    probe("R8 restored reversal still locks updates");

    // R9 same-cycle collisions
    apply(0, 0, 0, 0, 1, 0, 0, 0, g, e);   // normalise
    upd(0, 0);
    apply(1, 9, 0, 1, 0, 0, 0, 0, g, e);    // reverse beats update
    probe("R9 reverse over update");
    apply(0, 0, 0, 1, 1, 3, 0, 0, g, e);    // branch beats reverse
    chk("R9 branch result with reverse", {3'b0, g}, {3'b0, e});
    probe("R9 branch over reverse");
    upd(50, 0);
    apply(1, 2, 0, 0, 0, 0, 1, 0, g, e);    // save sees old state
    apply(1, 0, 1, 0, 0, 0, 0, 1, g, e);    // restore beats update
    probe("R9 save before update, restore over update");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule